// File: doc/BRIEF.md
# Predicated ALU with Zero and Carry Flags

This block is the arithmetic and logic stage of a small 16-bit processor whose instructions all carry a three-bit predicate. On each cycle where an instruction is issued, it receives the value of the destination register, an operand value and the low three bits of the opcode. The operand is either the effective address or the word read from memory; that choice, the effective-address adder, the register file and fetch all sit upstream or downstream. From these inputs and the two stored flags, the block produces a result word, a write-back strobe and the flag values that the next cycle will see.

The predicate evaluator decides whether the issued instruction takes effect. When it does not, the instruction still retires, but the block neither writes a register nor changes a flag. The zero and carry flags sit in a small register pair inside the block. They change only on a clock edge that carries a write-back. They are presented on the ports so that the surrounding pipeline can observe them.

There is no sequencing state: the datapath is combinational, and the only storage is the flag pair, which resets to zero.

Top module: `alu_pred_unit`

## Requirements
- R1: After reset, both flag outputs `flag_z` and `flag_c` are 0.
- R2: Predicate bits are `pred[2]` = carry test, `pred[1]` = zero test, `pred[0]` = invert. The instruction executes as follows: 110 always; 100 when Z=1; 010 when C=1; 000 when Z=1 and C=1; 101 when Z=0; 011 when C=0; 001 when Z=0 and C=0.
- R3: Predicate 111 never executes, so `wb_en` stays 0 whatever the flags are.
- R4: Function 000 (load) gives result = operand and leaves the carry unchanged.
- R5: Function 001 (add) gives result = dest + operand modulo 2^16, and the new carry is the carry-out of bit 15.
- R6: Function 110 (add with carry) gives result = dest + operand + C, and the new carry is the carry-out.
- R7: Functions 010 (and), 011 (or) and 100 (xor) give the bitwise result of dest and operand, and leave the carry unchanged.
- R8: Function 101 (rotate right) gives result = {C, operand[15:1]}, and the new carry is operand[0].
- R9: On every write-back, the new zero flag is 1 exactly when the result is 0.
- R10: When `issue` is 0 or the predicate fails, `wb_en` is 0 and both flags keep their values.
- R11: Function 111 (store) never writes back and never changes a flag.
- R12: `nxt_z` and `nxt_c` show the flag values that will be loaded at the next clock edge. `flag_z` and `flag_c` take those values on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag pair |
| issue | input | 1 | An instruction is presented this cycle |
| pred | input | 3 | Predicate field {carry test, zero test, invert} |
| op_fn | input | 3 | Low three opcode bits selecting the operation |
| dest_val | input | 16 | Current destination register value |
| opnd_val | input | 16 | Effective address or memory word |
| result | output | 16 | Value to write back |
| wb_en | output | 1 | Register write-back strobe |
| nxt_z | output | 1 | Zero flag after this cycle |
| nxt_c | output | 1 | Carry flag after this cycle |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |

## Verification
The bench builds the block with its default data width of 16. At that width the carry-out boundary (0xFFFF plus 1) and the wrap to a zero result can be reached directly. The same width lets a rotate carry a set flag into bit 15. For each of the four flag combinations, the bench walks all eight predicate codes, so every execute and skip decision is exercised against every flag state.

// File: rtl/alu_pred_pkg.sv
package alu_pred_pkg;

    typedef enum logic [2:0] {
        FN_LOAD  = 3'b000,
        FN_ADD   = 3'b001,
        FN_AND   = 3'b010,
        FN_OR    = 3'b011,
        FN_XOR   = 3'b100,
        FN_ROR   = 3'b101,
        FN_ADDC  = 3'b110,
        FN_STORE = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic skip_c;
        logic skip_z;
        logic invert;
    } pred_t;

endpackage

// File: rtl/alu_pred_eval.sv
module alu_pred_eval
    import alu_pred_pkg::*;
(
    input  logic [2:0] pred,
    input  logic       cur_z,
    input  logic       cur_c,
    output logic       take
);
    pred_t p;
    logic  tz, tc;

    always_comb begin
        p  = pred_t'(pred);
        tz = p.invert ? ~cur_z : cur_z;
        tc = p.invert ? ~cur_c : cur_c;
        if (p.skip_c && p.skip_z && p.invert)
            take = 1'b0;
        else
            take = (p.skip_c | tc) & (p.skip_z | tz);
    end
endmodule

// File: rtl/alu_pred_core.sv
module alu_pred_core
    import alu_pred_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] y,
    output logic              cout,
    output logic              writes,
    output logic              sets_c
);
    localparam int SUM_W = DATA_W + 1;

    alu_fn_e          f;
    logic [SUM_W-1:0] sum;

    always_comb begin
        f      = alu_fn_e'(fn);
        sum    = '0;
        y      = '0;
        cout   = 1'b0;
        writes = 1'b1;
        sets_c = 1'b0;
        unique case (f)
            FN_LOAD: y = b;
            FN_ADD: begin
                sum    = {1'b0, a} + {1'b0, b};
                y      = sum[DATA_W-1:0];
                cout   = sum[DATA_W];
                sets_c = 1'b1;
            end
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_ROR: begin
                y      = {cin, b[DATA_W-1:1]};
                cout   = b[0];
                sets_c = 1'b1;
            end
            FN_ADDC: begin
                sum    = {1'b0, a} + {1'b0, b} + SUM_W'(cin);
                y      = sum[DATA_W-1:0];
                cout   = sum[DATA_W];
                sets_c = 1'b1;
            end
            FN_STORE: writes = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_pred_flags.sv
module alu_pred_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic z_in,
    input  logic c_in,
    output logic z_q,
    output logic c_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else if (wr_en) begin
            z_q <= z_in;
            c_q <= c_in;
        end
    end

    // R10: no write, no flag movement
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(z_q) && $stable(c_q)));

    // R12: flags take the presented values on a write edge
    p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (z_q == $past(z_in) && c_q == $past(c_in)));
endmodule

// File: rtl/alu_pred_unit.sv
module alu_pred_unit
    import alu_pred_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [2:0]        pred,
    input  logic [2:0]        op_fn,
    input  logic [DATA_W-1:0] dest_val,
    input  logic [DATA_W-1:0] opnd_val,
    output logic [DATA_W-1:0] result,
    output logic              wb_en,
    output logic              nxt_z,
    output logic              nxt_c,
    output logic              flag_z,
    output logic              flag_c
);
    localparam int MSB = DATA_W - 1;

    logic take, core_c, writes, sets_c;

    alu_pred_eval u_eval (
        .pred  (pred),
        .cur_z (flag_z),
        .cur_c (flag_c),
        .take  (take)
    );

    alu_pred_core #(.DATA_W(DATA_W)) u_core (
        .fn     (op_fn),
        .a      (dest_val),
        .b      (opnd_val),
        .cin    (flag_c),
        .y      (result),
        .cout   (core_c),
        .writes (writes),
        .sets_c (sets_c)
    );

    always_comb begin
        wb_en = issue & take & writes;
        nxt_z = wb_en ? (result == '0) : flag_z;
        nxt_c = (wb_en & sets_c) ? core_c : flag_c;
    end

    alu_pred_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wb_en),
        .z_in  (nxt_z),
        .c_in  (nxt_c),
        .z_q   (flag_z),
        .c_q   (flag_c)
    );

    p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pred == 3'b111) |-> !wb_en);

    p_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fn == 3'b111) |=> ($stable(flag_z) && $stable(flag_c)));

    p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (flag_z == ($past(result) == '0)));

    p_ror_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && op_fn == FN_ROR) |-> (result[MSB] == flag_c));

    p_ror_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && op_fn == FN_ROR) |=> (flag_c == $past(opnd_val[0])));

    p_keep_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fn inside {FN_LOAD, FN_AND, FN_OR, FN_XOR}) |=> $stable(flag_c));
endmodule

// File: tb/alu_pred_unit_tb_top.sv
`timescale 1ns/1ps
module alu_pred_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [2:0]  pred = 3'b110;
    logic [2:0]  op_fn = 3'b000;
    logic [15:0] dest_val = '0;
    logic [15:0] opnd_val = '0;
    logic [15:0] result;
    logic        wb_en, nxt_z, nxt_c, flag_z, flag_c;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic mz = 1'b0, mc = 1'b0;

    typedef struct {
        logic [15:0] r;
        logic        wb, z, c, fz, fc;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    alu_pred_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue(issue), .pred(pred), .op_fn(op_fn),
        .dest_val(dest_val), .opnd_val(opnd_val), .result(result),
        .wb_en(wb_en), .nxt_z(nxt_z), .nxt_c(nxt_c),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    function automatic logic pred_ok(logic [2:0] p, logic z, logic c);
        case (p)
            3'b110: return 1'b1;
            3'b100: return z;
            3'b010: return c;
            3'b000: return z & c;
            3'b101: return ~z;
            3'b011: return ~c;
            3'b001: return ~z & ~c;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input logic iss, input logic [2:0] p, input logic [2:0] f,
                         input logic [15:0] d, input logic [15:0] s, input string req);
        exp_t e;
        logic [16:0] sm;
        logic co;
        @(negedge clk);
        issue = iss; pred = p; op_fn = f; dest_val = d; opnd_val = s;
        sm = '0; co = mc;
        case (f)
            3'd0: e.r = s;
            3'd1: begin sm = {1'b0, d} + {1'b0, s}; e.r = sm[15:0]; co = sm[16]; end
            3'd2: e.r = d & s;
            3'd3: e.r = d | s;
            3'd4: e.r = d ^ s;
            3'd5: begin e.r = {mc, s[15:1]}; co = s[0]; end
            3'd6: begin sm = {1'b0, d} + {1'b0, s} + {16'd0, mc}; e.r = sm[15:0]; co = sm[16]; end
            default: e.r = '0;
        endcase
        e.wb  = iss && pred_ok(p, mz, mc) && (f != 3'd7);
        e.z   = e.wb ? (e.r == 16'd0) : mz;
        e.c   = (e.wb && (f == 3'd1 || f == 3'd5 || f == 3'd6)) ? co : mc;
        e.fz  = mz;
        e.fc  = mc;
        e.req = req;
        sb.push_back(e);
        mz = e.z;
        mc = e.c;
    endtask

    // monitor: compares just before the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (wb_en !== e.wb || nxt_z !== e.z || nxt_c !== e.c ||
                    flag_z !== e.fz || flag_c !== e.fc || (e.wb && result !== e.r)) begin
                    errors++;
                    $display("FAIL %s: got r=%h wb=%b nz=%b nc=%b fz=%b fc=%b exp r=%h wb=%b nz=%b nc=%b fz=%b fc=%b",
                             e.req, result, wb_en, nxt_z, nxt_c, flag_z, flag_c,
                             e.r, e.wb, e.z, e.c, e.fz, e.fc);
                end
            end
        end
    end

    task automatic set_flags(input logic z, input logic c);
        if (c) drive(1, 3'b110, 3'd1, 16'hFFFF, z ? 16'h0001 : 16'h0002, "R5 setup");
        else   drive(1, 3'b110, 3'd1, 16'h0001, 16'h0001, "R5 setup");
        if (z && !c) drive(1, 3'b110, 3'd0, 16'h1111, 16'h0000, "R9 setup");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        checks++;
        if (flag_z !== 1'b0 || flag_c !== 1'b0 || wb_en !== 1'b0) begin
            errors++;
            $display("FAIL R1: got fz=%b fc=%b wb=%b exp 0 0 0", flag_z, flag_c, wb_en);
        end
        drive(1, 3'b110, 3'd0, 16'h1234, 16'h00A5, "R4 load");
        drive(1, 3'b110, 3'd0, 16'h1234, 16'h0000, "R9 load zero");
        drive(1, 3'b110, 3'd1, 16'hFFFF, 16'h0001, "R5 add wrap");
        drive(1, 3'b110, 3'd0, 16'h0000, 16'h7777, "R4 carry held");
        drive(1, 3'b110, 3'd6, 16'h0001, 16'h0001, "R6 adc cin=1");
        drive(1, 3'b110, 3'd6, 16'h8000, 16'h8000, "R6 adc cin=0 carry out");
        drive(1, 3'b110, 3'd2, 16'hF0F0, 16'h3C3C, "R7 and");
        drive(1, 3'b110, 3'd3, 16'hF0F0, 16'h0F0F, "R7 or");
        drive(1, 3'b110, 3'd4, 16'hAAAA, 16'hAAAA, "R7 xor zero");
        drive(1, 3'b110, 3'd5, 16'h0000, 16'h0003, "R8 ror cin=1");
        drive(1, 3'b110, 3'd5, 16'h0000, 16'h0002, "R8 ror cin=1 out 0");
        drive(1, 3'b110, 3'd5, 16'h0000, 16'h0001, "R8 ror to zero");
        drive(1, 3'b110, 3'd7, 16'h0000, 16'h0000, "R11 store");
        drive(1, 3'b110, 3'd7, 16'h5555, 16'h0001, "R11 store flags held");
        drive(0, 3'b110, 3'd1, 16'hFFFF, 16'h0001, "R10 no issue");
        drive(1, 3'b111, 3'd0, 16'h0000, 16'h0000, "R3 never");
        for (int st = 0; st < 4; st++) begin
            for (int p = 0; p < 8; p++) begin
                set_flags(st[1], st[0]);
                drive(1, 3'(p), 3'd2, 16'hFFFF, 16'h0000, "R2 R3 R10 predicate");
                drive(1, 3'b110, 3'd3, 16'h0000, 16'h0001, "R12 flags after probe");
            end
        end
        repeat (3) @(negedge clk);
        issue = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R12: got %0d pending exp 0", sb.size());
        end
        finish_run();
    end
endmodule